// File: doc/BRIEF.md
# Auto-Zeroed Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope analog-to-digital converter. The integrator, buffer and comparator stay in the analog domain. The block steers them through six timed phases:

1. Auto-zero: the integrator is shorted while the offset capacitor charges.
2. Offset measurement: the block measures the comparator offset as a clock count.
3. A second auto-zero.
4. Integration of the unknown input over a fixed window.
5. De-integration against the reference, for as many clocks as the stored offset count. This is the zero correction.
6. Further de-integration, during which the conversion count is taken.

The comparator reaches the block as a plain synchronous digital input. The block drives one-hot switch controls toward the analog side. The input orientation used in phase 4 comes from the sign that the previous conversion detected.

Each conversion ends with a one-clock end-of-conversion pulse. The result register holds a magnitude count, a sign, an overrange flag and an underrange flag. It is updated only when a rising edge on the display-update input was seen early enough in the cycle. If the display-update input is looped back from the end-of-conversion output, every conversion after the first one is shown.

Top module: `dsadc_seq`

## Requirements
- R1: An active-low asynchronous reset forces phase 1, with `phase_o`=1, `sw_short_o`=1, `eoc_o`=0 and the result outputs (`count_o`, `neg_o`, `ovr_o`, `und_o`) all 0. The stored offset and the stored sign also clear to 0.
- R2: Phases 1 and 3 each last exactly AZ_LEN clocks. In both phases `sw_short_o` is the only switch output that is high.
- R3: Phase 2 drives `sw_ofs_o`. It ends on the first clock on which `cmp_i` is high, or after OFS_MAX clocks without a trip. The stored offset is the number of phase-2 clocks before the trip clock, or OFS_MAX-1 if there was no trip.
- R4: Phase 4 lasts INT_LEN clocks. `sw_inn_o` is high in phase 4 when the previous conversion's sign was negative, and `sw_inp_o` is high otherwise. `cmp_i` on the last clock of phase 4 is this conversion's sign (1 = negative).
- R5: Phase 5 lasts as many clocks as the stored offset, and is skipped when the offset is 0. `sw_ref_o` is the only switch output high in phases 5 and 6.
- R6: The raw count is the number of phase-6 clocks before the clock on which `cmp_i` is high. If no trip arrives within SEG6_MAX clocks, phase 6 ends and the count saturates at SEG6_MAX.
- R7: `eoc_o` is high for exactly one clock: the first clock of phase 1 that follows the end of phase 6.
- R8: The result outputs load at the end of phase 6 only if a rising edge of `disp_upd_i` was sampled while `phase_o` was 1 to 4 in that conversion. Otherwise they hold their value.
- R9: When loaded, `ovr_o` = (raw count > OVR_LIM) and `und_o` = (raw count < UND_LIM).
- R10: `phase_o` carries the phase number 1 to 6. Phases advance only 1→2→3→4→5→6→1, with 4→6 taken when phase 5 is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset to start of cycle |
| cmp_i | input | 1 | Comparator trip (synchronous) |
| disp_upd_i | input | 1 | Display-update request; rising edge arms the result load |
| phase_o | output | 3 | Current phase number 1..6 |
| sw_short_o | output | 1 | Short integrator / charge offset capacitor |
| sw_ofs_o | output | 1 | Offset measurement ramp |
| sw_inp_o | output | 1 | Integrate input, positive orientation |
| sw_inn_o | output | 1 | Integrate input, negative orientation |
| sw_ref_o | output | 1 | De-integrate from reference |
| eoc_o | output | 1 | End-of-conversion pulse |
| count_o | output | $clog2(SEG6_MAX+1) | Latched magnitude count |
| neg_o | output | 1 | Latched sign, 1 = negative |
| ovr_o | output | 1 | Latched overrange flag |
| und_o | output | 1 | Latched underrange flag |

## Verification
The assertions check the following on every cycle:
- Exactly one switch output is high.
- The phase-2 and phase-6 counters stay inside their windows.
- The second auto-zero always hands over to integration.
- End-of-conversion never lasts two clocks and always coincides with phase 1.
- The result outputs never move without a load.
- The two range flags are never set together, and a saturated count always raises overrange.

Only the bench's sweeps can show the arithmetic: the length of every phase for each offset trip point, the raw count and its saturation, the sign handed from one conversion to the next, and whether a display-update edge that arrives late is ignored.

// File: rtl/dsadc_pkg.sv
`timescale 1ns/1ps
package dsadc_pkg;

  typedef enum logic [2:0] {
    PH_AZ1   = 3'd1,
    PH_OFS   = 3'd2,
    PH_AZ2   = 3'd3,
    PH_INT   = 3'd4,
    PH_DEINT = 3'd5,
    PH_CNT   = 3'd6
  } phase_e;

  function automatic logic above_limit(input int unsigned val, input int unsigned lim);
    return val > lim;
  endfunction

  function automatic logic below_limit(input int unsigned val, input int unsigned lim);
    return val < lim;
  endfunction

endpackage

// File: rtl/dsadc_phase_ctl.sv
`timescale 1ns/1ps
module dsadc_phase_ctl
  import dsadc_pkg::*;
#(
  parameter int unsigned AZ_LEN   = 4000,
  parameter int unsigned INT_LEN  = 4000,
  parameter int unsigned OFS_MAX  = 800,
  parameter int unsigned SEG6_MAX = 4000,
  parameter int unsigned CW       = 12,
  parameter int unsigned OW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_i,
  input  logic [OW-1:0] ofs_len,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          ph_end
);

  phase_e nxt;

  always_comb begin
    case (phase)
      PH_AZ1, PH_AZ2: ph_end = (cnt == CW'(AZ_LEN - 1));
      PH_OFS:         ph_end = cmp_i || (cnt == CW'(OFS_MAX - 1));
      PH_INT:         ph_end = (cnt == CW'(INT_LEN - 1));
      PH_DEINT:       ph_end = (cnt == (CW'(ofs_len) - CW'(1)));
      PH_CNT:         ph_end = cmp_i || (cnt == CW'(SEG6_MAX - 1));
      default:        ph_end = 1'b1;
    endcase
  end

  always_comb begin
    case (phase)
      PH_AZ1:   nxt = PH_OFS;
      PH_OFS:   nxt = PH_AZ2;
      PH_AZ2:   nxt = PH_INT;
      PH_INT:   nxt = (ofs_len == '0) ? PH_CNT : PH_DEINT;
      PH_DEINT: nxt = PH_CNT;
      default:  nxt = PH_AZ1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_AZ1;
      cnt   <= '0;
    end else if (ph_end) begin
      phase <= nxt;
      cnt   <= '0;
    end else begin
      cnt   <= cnt + CW'(1);
    end
  end

  AST_OFS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OFS) |-> (cnt < CW'(OFS_MAX))); // R3
  AST_CNT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CNT) |-> (cnt < CW'(SEG6_MAX))); // R6
  AST_AZ2_TO_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_AZ2 && ph_end) |=> (phase == PH_INT)); // R10

endmodule

// File: rtl/dsadc_upd_gate.sv
`timescale 1ns/1ps
module dsadc_upd_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic window_i,
  input  logic done_i,
  output logic load_o
);

  logic upd_q;
  logic armed_q;
  logic upd_edge;

  assign upd_edge = upd_i & ~upd_q;
  assign load_o   = done_i & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      upd_q <= upd_i;
      if (done_i)                    armed_q <= 1'b0;
      else if (upd_edge && window_i) armed_q <= 1'b1;
    end
  end

  AST_NO_LATE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_i && !armed_q) |=> !armed_q); // R8

endmodule

// File: rtl/dsadc_result_reg.sv
`timescale 1ns/1ps
module dsadc_result_reg
  import dsadc_pkg::*;
#(
  parameter int unsigned RW       = 12,
  parameter int unsigned OVR_LIM  = 1999,
  parameter int unsigned UND_LIM  = 180,
  parameter int unsigned SEG6_MAX = 4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [RW-1:0] raw_i,
  input  logic          sign_i,
  output logic [RW-1:0] count_o,
  output logic          neg_o,
  output logic          ovr_o,
  output logic          und_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      neg_o   <= 1'b0;
      ovr_o   <= 1'b0;
      und_o   <= 1'b0;
    end else if (load_i) begin
      count_o <= raw_i;
      neg_o   <= sign_i;
      ovr_o   <= above_limit(32'(raw_i), OVR_LIM);
      und_o   <= below_limit(32'(raw_i), UND_LIM);
    end
  end

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable({count_o, neg_o, ovr_o, und_o})); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovr_o && und_o)); // R9
  AST_SAT_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && raw_i == RW'(SEG6_MAX)) |=> ovr_o); // R6

endmodule

// File: rtl/dsadc_seq.sv
`timescale 1ns/1ps
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int unsigned AZ_LEN   = 4000,
  parameter int unsigned INT_LEN  = 4000,
  parameter int unsigned OFS_MAX  = 800,
  parameter int unsigned SEG6_MAX = 4000,
  parameter int unsigned OVR_LIM  = 1999,
  parameter int unsigned UND_LIM  = 180,
  localparam int unsigned LEN_A   = (AZ_LEN > INT_LEN) ? AZ_LEN : INT_LEN,
  localparam int unsigned LEN_MAX = (LEN_A > SEG6_MAX) ? LEN_A : SEG6_MAX,
  localparam int unsigned CW      = $clog2(LEN_MAX + 1),
  localparam int unsigned OW      = $clog2(OFS_MAX),
  localparam int unsigned RW      = $clog2(SEG6_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_i,
  input  logic          disp_upd_i,
  output logic [2:0]    phase_o,
  output logic          sw_short_o,
  output logic          sw_ofs_o,
  output logic          sw_inp_o,
  output logic          sw_inn_o,
  output logic          sw_ref_o,
  output logic          eoc_o,
  output logic [RW-1:0] count_o,
  output logic          neg_o,
  output logic          ovr_o,
  output logic          und_o
);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          ph_end;
  logic [OW-1:0] ofs_q;
  logic          pol_q;
  logic          eoc_q;

  // named internal events
  logic          ofs_store;
  logic          sign_take;
  logic          conv_done;
  logic          upd_window;
  logic          latch_en;
  logic [RW-1:0] raw_count;

  dsadc_phase_ctl #(
    .AZ_LEN(AZ_LEN), .INT_LEN(INT_LEN), .OFS_MAX(OFS_MAX),
    .SEG6_MAX(SEG6_MAX), .CW(CW), .OW(OW)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .ofs_len(ofs_q),
    .phase(phase), .cnt(cnt), .ph_end(ph_end)
  );

  assign ofs_store  = (phase == PH_OFS) && ph_end;
  assign sign_take  = (phase == PH_INT) && ph_end;
  assign conv_done  = (phase == PH_CNT) && ph_end;
  assign upd_window = (phase == PH_AZ1) || (phase == PH_OFS) ||
                      (phase == PH_AZ2) || (phase == PH_INT);
  assign raw_count  = cmp_i ? RW'(cnt) : RW'(SEG6_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      pol_q <= 1'b0;
      eoc_q <= 1'b0;
    end else begin
      if (ofs_store) ofs_q <= cnt[OW-1:0];
      if (sign_take) pol_q <= cmp_i;
      eoc_q <= conv_done;
    end
  end

  dsadc_upd_gate u_gate (
    .clk(clk), .rst_n(rst_n), .upd_i(disp_upd_i), .window_i(upd_window),
    .done_i(conv_done), .load_o(latch_en)
  );

  dsadc_result_reg #(
    .RW(RW), .OVR_LIM(OVR_LIM), .UND_LIM(UND_LIM), .SEG6_MAX(SEG6_MAX)
  ) u_res (
    .clk(clk), .rst_n(rst_n), .load_i(latch_en), .raw_i(raw_count),
    .sign_i(pol_q), .count_o(count_o), .neg_o(neg_o), .ovr_o(ovr_o), .und_o(und_o)
  );

  assign phase_o    = phase;
  assign sw_short_o = (phase == PH_AZ1) || (phase == PH_AZ2);
  assign sw_ofs_o   = (phase == PH_OFS);
  assign sw_inp_o   = (phase == PH_INT) && !pol_q;
  assign sw_inn_o   = (phase == PH_INT) && pol_q;
  assign sw_ref_o   = (phase == PH_DEINT) || (phase == PH_CNT);
  assign eoc_o      = eoc_q;

  AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sw_short_o, sw_ofs_o, sw_inp_o, sw_inn_o, sw_ref_o}) == 1); // R2
  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |=> !eoc_o); // R7
  AST_EOC_IN_AZ1: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |-> (phase_o == 3'd1)); // R7

endmodule

// File: tb/sim_dsadc_seq.sv
`timescale 1ns/1ps
module sim_dsadc_seq;

  localparam int AZ = 5, INTL = 6, OMAX = 8, S6 = 30, OVL = 19, UNL = 3;
  localparam int RW = $clog2(S6 + 1);

  logic clk = 1'b0, rst_n = 1'b0, cmp_i = 1'b0, disp_upd = 1'b0;
  logic [2:0] phase_o;
  logic sw_short_o, sw_ofs_o, sw_inp_o, sw_inn_o, sw_ref_o, eoc_o;
  logic [RW-1:0] count_o;
  logic neg_o, ovr_o, und_o;

  dsadc_seq #(.AZ_LEN(AZ), .INT_LEN(INTL), .OFS_MAX(OMAX), .SEG6_MAX(S6),
              .OVR_LIM(OVL), .UND_LIM(UNL)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .disp_upd_i(disp_upd),
    .phase_o(phase_o), .sw_short_o(sw_short_o), .sw_ofs_o(sw_ofs_o),
    .sw_inp_o(sw_inp_o), .sw_inn_o(sw_inn_o), .sw_ref_o(sw_ref_o),
    .eoc_o(eoc_o), .count_o(count_o), .neg_o(neg_o), .ovr_o(ovr_o), .und_o(und_o));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int sc_k = 0, sc_sg = 0, sc_n = 0;
  int pcnt = 0, prev_ph = 0;
  int len [8], last_len [8];
  int sw_bad = 0, last_sw_bad = 0, ord_bad = 0, last_ord_bad = 0;
  bit inn_seen = 0, inp_seen = 0, last_inn = 0, last_inp = 0;
  int exp_cnt = 0, exp_neg = 0, exp_ovr = 0, exp_und = 0, exp_prev_sg = 0;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit legal_step(input int p, input int q);
    return (p == 1 && q == 2) || (p == 2 && q == 3) || (p == 3 && q == 4) ||
           (p == 4 && q == 5) || (p == 4 && q == 6) || (p == 5 && q == 6) ||
           (p == 6 && q == 1);
  endfunction

  task automatic clear_mon();
    for (int i = 0; i < 8; i++) len[i] = 0;
    sw_bad = 0; ord_bad = 0; inn_seen = 0; inp_seen = 0;
  endtask

  // monitor and comparator stand-in
  always @(negedge clk) begin
    if (!rst_n) begin
      clear_mon();
      pcnt = 0; prev_ph = 0; cmp_i = 1'b0;
    end else begin
      if (eoc_o) begin
        for (int i = 0; i < 8; i++) last_len[i] = len[i];
        last_sw_bad = sw_bad; last_ord_bad = ord_bad;
        last_inn = inn_seen; last_inp = inp_seen;
        clear_mon();
      end
      if (int'(phase_o) != prev_ph) begin
        if (prev_ph != 0 && !legal_step(prev_ph, int'(phase_o))) ord_bad++;
        pcnt = 0;
      end else pcnt++;
      prev_ph = int'(phase_o);
      len[phase_o]++;
      case (phase_o)
        3'd1, 3'd3: if ({sw_short_o, sw_ofs_o, sw_inp_o, sw_inn_o, sw_ref_o} != 5'b10000) sw_bad++;
        3'd2:       if ({sw_short_o, sw_ofs_o, sw_inp_o, sw_inn_o, sw_ref_o} != 5'b01000) sw_bad++;
        3'd4:       if (sw_short_o || sw_ofs_o || sw_ref_o || (sw_inp_o == sw_inn_o)) sw_bad++;
        3'd5, 3'd6: if ({sw_short_o, sw_ofs_o, sw_inp_o, sw_inn_o, sw_ref_o} != 5'b00001) sw_bad++;
        default:    sw_bad++;
      endcase
      if (phase_o == 3'd4) begin
        inn_seen |= sw_inn_o;
        inp_seen |= sw_inp_o;
      end
      case (phase_o)
        3'd2:    cmp_i = (pcnt == sc_k);
        3'd4:    cmp_i = (pcnt == INTL - 1) ? sc_sg[0] : 1'b0;
        3'd6:    cmp_i = (pcnt == sc_n);
        default: cmp_i = 1'b0;
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R7 watchdog: no completion actual=%0d expected<=150000", cyc);
      summary();
      $finish;
    end
  end

  // du: 0 none, 1 edge in phase 1, 2 edge in phase 6 (too late)
  task automatic run_conv(input int k, input int sg, input int n, input int du);
    int raw, ofs;
    sc_k = k; sc_sg = sg; sc_n = n;
    @(posedge clk); #1;
    if (du == 1) begin
      disp_upd = 1'b1; @(posedge clk); #1; disp_upd = 1'b0;
    end else if (du == 2) begin
      while (phase_o != 3'd6) begin @(posedge clk); #1; end
      disp_upd = 1'b1; @(posedge clk); #1; disp_upd = 1'b0;
    end
    while (!eoc_o) begin @(posedge clk); #1; end
    chk("R7 phase at eoc", int'(phase_o), 1);
    @(negedge clk); #1;
    raw = (n < S6) ? n : S6;
    ofs = (k < OMAX) ? k : OMAX - 1;
    chk("R2 phase1 length", last_len[1], AZ);
    chk("R3 phase2 length", last_len[2], (k < OMAX) ? k + 1 : OMAX);
    chk("R2 phase3 length", last_len[3], AZ);
    chk("R4 phase4 length", last_len[4], INTL);
    chk("R5 phase5 length = offset", last_len[5], ofs);
    chk("R6 phase6 length", last_len[6], (n < S6) ? n + 1 : S6);
    chk("R2 switch pattern errors", last_sw_bad, 0);
    chk("R10 illegal phase steps", last_ord_bad, 0);
    chk("R4 negative orientation used", int'(last_inn), exp_prev_sg);
    chk("R4 positive orientation used", int'(last_inp), 1 - exp_prev_sg);
    exp_prev_sg = sg;
    if (du == 1) begin
      exp_cnt = raw; exp_neg = sg;
      exp_ovr = (raw > OVL) ? 1 : 0;
      exp_und = (raw < UNL) ? 1 : 0;
    end
    chk("R6 R8 count", int'(count_o), exp_cnt);
    chk("R4 R8 sign", int'(neg_o), exp_neg);
    chk("R9 overrange", int'(ovr_o), exp_ovr);
    chk("R9 underrange", int'(und_o), exp_und);
  endtask

  task automatic reset_checks();
    chk("R1 phase", int'(phase_o), 1);
    chk("R1 short switch", int'(sw_short_o), 1);
    chk("R1 eoc", int'(eoc_o), 0);
    chk("R1 count", int'(count_o), 0);
    chk("R1 flags", int'({neg_o, ovr_o, und_o}), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 reset_checks();
    rst_n = 1'b1;
    for (int k = 0; k <= OMAX; k++) begin
      for (int n = 0; n <= S6; n++) begin
        int du;
        du = (n % 7 == 3) ? 0 : ((n % 7 == 5) ? 2 : 1);
        run_conv(k, (k + n) % 2, n, du);
      end
    end
    // R1: reset in the middle of a conversion
    sc_k = 2; sc_sg = 1; sc_n = 4;
    while (phase_o != 3'd4) begin @(posedge clk); #1; end
    rst_n = 1'b0; #1;
    reset_checks();
    @(posedge clk); #1;
    rst_n = 1'b1;
    exp_prev_sg = 0; exp_cnt = 0; exp_neg = 0; exp_ovr = 0; exp_und = 0;
    run_conv(3, 1, 12, 1);
    run_conv(0, 0, 2, 1);
    summary();
    $finish;
  end

endmodule